// File: doc/BRIEF.md
# Multiple Sum-of-Absolute-Differences Unit

This unit compares a short reference pattern against a sliding window of pixels in a single operation. It takes two 128-bit operands, each holding sixteen unsigned bytes, and a small control word. The control picks a four-byte reference from operand B and an eleven-byte window from operand A. It returns eight 16-bit sums. Sum k adds the four absolute byte differences between the reference and the window bytes that start at position k.

A typical use is block-matching motion search. One call scores eight candidate positions at once. Successive calls change the offsets to walk the reference and the window through the operands.

The datapath has two register stages. The absolute differences are registered first, and then the adder trees are registered. Operands and control are taken on any cycle with the input-valid flag high. The matching output-valid pulse follows a fixed two cycles later, and the unit accepts one operation per cycle.

Top module: `msad_unit`

## Requirements
- R1: Bit 2 of `ctrlSel` selects the window start in A. Bit 2 = 0 starts the window at byte 0, and bit 2 = 1 starts it at byte 4.
- R2: Bits 1:0 of `ctrlSel` select the reference start in B at byte 4 × value, which is byte 0, 4, 8 or 12.
- R3: Byte m of an operand occupies bits [8m+7:8m], and lane k of `result` occupies bits [16k+15:16k]. Lane k (k = 0..7) equals the sum over n = 0..3 of |A[i+k+n] − B[j+n]|, where i and j are the starts set by R1 and R2. All bytes are unsigned.
- R4: Each lane reaches at most 1020 with no saturation, and bits [15:10] of every lane are zero.
- R5: Bits of `ctrlSel` above bit 2 have no effect on the result.
- R6: An operation sampled with `inValid` high at a rising edge produces `outValid` high, with its `result`, after exactly the second following rising edge. `outValid` is low after the first of those edges.
- R7: The unit accepts operations on consecutive cycles. Each one produces its own result on consecutive cycles, in order.
- R8: A synchronous active-high `rst` drives `outValid` low and discards operations still in the pipeline. `outValid` is never high without an accepted operation two cycles earlier.
- R9: Operand and control changes while `inValid` is low are ignored. `outValid` stays low and `result` holds its last value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Operands and control valid this cycle |
| opA | input | 128 | Window operand, sixteen unsigned bytes |
| opB | input | 128 | Reference operand, sixteen unsigned bytes |
| ctrlSel | input | 8 | Offset control; only bits 2:0 are used |
| outValid | output | 1 | Result valid this cycle |
| result | output | 128 | Eight 16-bit unsigned SAD lanes |

## Verification
The hardest case to reach is an operation in flight when reset arrives. Its differences already sit in the first stage, and it must vanish without a stray valid pulse. The bench issues an operation and raises reset in the cycle between the two stages.

A second hard case is a run of back-to-back operations, each with a different offset pair. Each result must pair with its own operands and not with those of a neighbour. The bench streams eight generated operand sets, one per cycle, covering all eight offset codes, and checks every output cycle against an independent model.

// File: rtl/msad_pkg.sv
package msad_pkg;
  // Load strobes issued by the control to the datapath stages
  typedef struct packed {
    logic s1Load;  // capture absolute differences
    logic s2Load;  // capture lane sums
  } msadStrobe_t;
endpackage

// File: rtl/msad_ctrl.sv
module msad_ctrl
  import msad_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        inValid,
  output msadStrobe_t stb,
  output logic        outValid
);
  logic s1Valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1Valid  <= 1'b0;
      outValid <= 1'b0;
    end else begin
      s1Valid  <= inValid;
      outValid <= s1Valid;
    end
  end

  assign stb.s1Load = inValid;
  assign stb.s2Load = s1Valid;

  // R6: fixed two-cycle latency from accept to valid output
  p_latency_r6: assert property (@(posedge clk) disable iff (rst)
    inValid |-> ##2 outValid);

  // R8: no valid output without an accepted operation two cycles before
  p_no_spurious_r8: assert property (@(posedge clk) disable iff (rst)
    outValid |-> $past(inValid, 2));
endmodule

// File: rtl/msad_dp.sv
module msad_dp
  import msad_pkg::*;
#(
  parameter int DATA_W = 128,
  parameter int BYTE_W = 8,
  parameter int LANES  = 8,
  parameter int TAPS   = 4,
  parameter int A_STEP = 4,
  parameter int B_STEP = 4,
  parameter int LANE_W = 16,
  parameter int CTRL_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  msadStrobe_t             stb,
  input  logic [DATA_W-1:0]       opA,
  input  logic [DATA_W-1:0]       opB,
  input  logic [CTRL_W-1:0]       ctrlSel,
  output logic [LANES*LANE_W-1:0] result
);
  localparam int BYTES  = DATA_W / BYTE_W;
  localparam int WIN    = LANES + TAPS - 1;
  localparam int IDX_W  = $clog2(BYTES);
  localparam int MAXSUM = TAPS * ((1 << BYTE_W) - 1);

  logic [BYTE_W-1:0] aByte [BYTES];
  logic [BYTE_W-1:0] bByte [BYTES];
  logic [BYTE_W-1:0] winA  [WIN];
  logic [BYTE_W-1:0] refB  [TAPS];
  logic [BYTE_W-1:0] diffD [LANES][TAPS];
  logic [BYTE_W-1:0] diffQ [LANES][TAPS];
  logic              aSel;
  logic [1:0]        bSel;

  assign aSel = ctrlSel[2];
  assign bSel = ctrlSel[1:0];

  for (genvar m = 0; m < BYTES; m++) begin : g_unpack
    assign aByte[m] = opA[m*BYTE_W +: BYTE_W];
    assign bByte[m] = opB[m*BYTE_W +: BYTE_W];
  end

  // Window in A: base 0 or A_STEP
  for (genvar w = 0; w < WIN; w++) begin : g_win
    assign winA[w] = aSel ? aByte[w + A_STEP] : aByte[w];
  end

  // Reference in B: base bSel * B_STEP
  always_comb begin
    for (int n = 0; n < TAPS; n++) begin
      refB[n] = bByte[IDX_W'(bSel) * IDX_W'(B_STEP) + IDX_W'(n)];
    end
  end

  // Stage 1: absolute differences
  for (genvar k = 0; k < LANES; k++) begin : g_lane_d
    for (genvar n = 0; n < TAPS; n++) begin : g_tap_d
      assign diffD[k][n] = (winA[k+n] > refB[n]) ? (winA[k+n] - refB[n])
                                                 : (refB[n] - winA[k+n]);
      always_ff @(posedge clk) begin
        if (rst)             diffQ[k][n] <= '0;
        else if (stb.s1Load) diffQ[k][n] <= diffD[k][n];
      end
    end
  end

  // Stage 2: adder trees per lane
  for (genvar k = 0; k < LANES; k++) begin : g_lane_s
    logic [LANE_W-1:0] laneSum;
    always_comb begin
      laneSum = '0;
      for (int n = 0; n < TAPS; n++) begin
        laneSum = laneSum + LANE_W'(diffQ[k][n]);
      end
    end
    always_ff @(posedge clk) begin
      if (rst)             result[k*LANE_W +: LANE_W] <= '0;
      else if (stb.s2Load) result[k*LANE_W +: LANE_W] <= laneSum;
    end

    // R4: lane never exceeds the largest possible sum
    p_lane_max_r4: assert property (@(posedge clk) disable iff (rst)
      result[k*LANE_W +: LANE_W] <= LANE_W'(MAXSUM));
  end

  // R9: result holds when no stage-2 load occurred
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !stb.s2Load |=> $stable(result));
endmodule

// File: rtl/msad_unit.sv
module msad_unit
  import msad_pkg::*;
#(
  parameter int DATA_W = 128,
  parameter int BYTE_W = 8,
  parameter int LANES  = 8,
  parameter int TAPS   = 4,
  parameter int LANE_W = 16,
  parameter int CTRL_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    inValid,
  input  logic [DATA_W-1:0]       opA,
  input  logic [DATA_W-1:0]       opB,
  input  logic [CTRL_W-1:0]       ctrlSel,
  output logic                    outValid,
  output logic [LANES*LANE_W-1:0] result
);
  localparam int SUM_W = $clog2(TAPS * ((1 << BYTE_W) - 1) + 1);

  msadStrobe_t stb;

  msad_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .stb      (stb),
    .outValid (outValid)
  );

  msad_dp #(
    .DATA_W (DATA_W),
    .BYTE_W (BYTE_W),
    .LANES  (LANES),
    .TAPS   (TAPS),
    .A_STEP (4),
    .B_STEP (4),
    .LANE_W (LANE_W),
    .CTRL_W (CTRL_W)
  ) u_dp (
    .clk     (clk),
    .rst     (rst),
    .stb     (stb),
    .opA     (opA),
    .opB     (opB),
    .ctrlSel (ctrlSel),
    .result  (result)
  );

  // R4: upper lane bits are zero on every valid output
  for (genvar k = 0; k < LANES; k++) begin : g_upper
    p_upper_zero_r4: assert property (@(posedge clk) disable iff (rst)
      outValid |-> (result[k*LANE_W + SUM_W +: (LANE_W - SUM_W)] == '0));
  end
endmodule

// File: tb/msad_unit_test.sv
`timescale 1ns/1ps
module msad_unit_test;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         inValid = 1'b0;
  logic [127:0] opA = '0;
  logic [127:0] opB = '0;
  logic [7:0]   ctrlSel = '0;
  logic         outValid;
  logic [127:0] result;

  int testCount = 0;
  int failCount = 0;

  always #4 clk = ~clk;

  msad_unit uut (
    .clk(clk), .rst(rst), .inValid(inValid), .opA(opA), .opB(opB),
    .ctrlSel(ctrlSel), .outValid(outValid), .result(result)
  );

  typedef struct packed {
    logic [127:0] a;
    logic [127:0] b;
    logic [7:0]   c;
    logic [127:0] e;
  } vec_t;

  localparam logic [127:0] SEQ  = 128'h0f0e0d0c0b0a09080706050403020100;
  localparam logic [127:0] E000 = {16'd28, 16'd24, 16'd20, 16'd16, 16'd12, 16'd8, 16'd4, 16'd0};
  localparam logic [127:0] E001 = {16'd12, 16'd8, 16'd4, 16'd0, 16'd4, 16'd8, 16'd12, 16'd16};
  localparam logic [127:0] E111 = {16'd4, 16'd8, 16'd12, 16'd16, 16'd20, 16'd24, 16'd28, 16'd32};
  localparam logic [127:0] E100 = {16'd44, 16'd40, 16'd36, 16'd32, 16'd28, 16'd24, 16'd20, 16'd16};
  localparam logic [127:0] EMAX = {8{16'd1020}};
  localparam int NVEC = 7;
  localparam vec_t TBL [NVEC] = '{
    '{SEQ, SEQ, 8'h00, E000},          // R3 base case
    '{SEQ, SEQ, 8'h01, E001},          // R2 reference at byte 4
    '{SEQ, SEQ, 8'h07, E111},          // R1 R2 both offsets
    '{SEQ, SEQ, 8'h04, E100},          // R1 window at byte 4
    '{{16{8'hff}}, '0, 8'h00, EMAX},   // R4 largest sum
    '{SEQ, SEQ, 8'hf9, E001},          // R5 upper control bits set
    '{SEQ, SEQ, 8'h0c, E100}           // R5 bit 3 set
  };
  localparam string TAGS [NVEC] = '{"R3", "R2", "R1", "R1", "R4", "R5", "R5"};

  function automatic logic [127:0] model(logic [127:0] a, logic [127:0] b, logic [7:0] c);
    logic [127:0] r;
    int i, j, s, x, y;
    r = '0;
    i = c[2] ? 4 : 0;
    j = 4 * int'(c[1:0]);
    for (int k = 0; k < 8; k++) begin
      s = 0;
      for (int n = 0; n < 4; n++) begin
        x = int'(a[8*(i+k+n) +: 8]);
        y = int'(b[8*(j+n) +: 8]);
        s += (x > y) ? x - y : y - x;
      end
      r[16*k +: 16] = 16'(s);
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary;
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
  endtask

  // Single operation: drive, expect nothing after one edge, result after two
  task automatic runOne(input logic [127:0] a, input logic [127:0] b,
                        input logic [7:0] c, input logic [127:0] e, input string req);
    @(negedge clk);
    opA = a; opB = b; ctrlSel = c; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    chk("R6 early", {127'd0, outValid}, 128'd0);
    @(negedge clk);
    chk("R6 valid", {127'd0, outValid}, 128'd1);
    chk(req, result, e);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    failCount++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    logic [127:0] expQ [8];
    logic [127:0] held;
    logic [31:0]  seed;
    seed = 32'h1234_5678;

    // R8: reset state
    repeat (3) @(negedge clk);
    chk("R8 reset", {127'd0, outValid}, 128'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R8 idle", {127'd0, outValid}, 128'd0);

    // Table walk
    for (int v = 0; v < NVEC; v++) begin
      runOne(TBL[v].a, TBL[v].b, TBL[v].c, TBL[v].e, TAGS[v]);
    end

    // R9: changes while inValid low are ignored
    held = result;
    for (int t = 0; t < 3; t++) begin
      @(negedge clk);
      opA = ~opA; opB = opB ^ 128'h5a; ctrlSel = 8'(t + 2);
      chk("R9 valid low", {127'd0, outValid}, 128'd0);
      chk("R9 hold", result, held);
    end

    // R7: back-to-back stream with every offset code
    for (int t = 0; t < 10; t++) begin
      @(negedge clk);
      if (t >= 2) begin
        chk("R7 stream valid", {127'd0, outValid}, 128'd1);
        chk("R7 stream data", result, expQ[t-2]);
      end
      if (t < 8) begin
        logic [127:0] a, b;
        for (int w = 0; w < 4; w++) begin
          seed = seed * 32'd1103515245 + 32'd12345;
          a[32*w +: 32] = seed;
          seed = seed * 32'd1103515245 + 32'd12345;
          b[32*w +: 32] = seed;
        end
        opA = a; opB = b; ctrlSel = {5'(t * 3), 3'(t)};
        expQ[t] = model(a, b, {5'd0, 3'(t)});
        inValid = 1'b1;
      end else begin
        inValid = 1'b0;
      end
    end
    @(negedge clk);
    chk("R8 stream end", {127'd0, outValid}, 128'd0);

    // R8: reset while an operation sits in stage 1
    @(negedge clk);
    opA = SEQ; opB = SEQ; ctrlSel = 8'h00; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0; rst = 1'b1;
    @(negedge clk);
    chk("R8 flush", {127'd0, outValid}, 128'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R8 flush after", {127'd0, outValid}, 128'd0);

    // R2 with reference at byte 8, checked against the model
    runOne(SEQ, SEQ, 8'h02, model(SEQ, SEQ, 8'h02), "R2 ref byte 8");

    summary();
    $finish;
  end
endmodule